// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block sits between a processor with a 16-bit address bus and a physical memory made of two 16 KB ROM pages and eight 16 KB RAM pages. The processor address space is split into four 16 KB windows. The bottom window shows one of the two ROM pages. The next two windows are wired to RAM pages 5 and 2. The top window shows any one of the eight RAM pages. For every address the block gives a page number, a ROM/RAM flag and a 14-bit offset inside the page.

Software changes the mapping by writing a paging byte with an I/O write. The port decode is partial: only address lines 15 and 1 are examined. The paging byte also chooses the display page, between page 5 and page 7, and the ROM page. One bit in the byte locks the register until the next reset. The block also flags accesses that land in the odd-numbered RAM pages, which are slowed by the video side. It blocks writes into ROM.

There is no stream interface. The processor cycle signals are plain strobes, and all mapping outputs are combinational from the current address and the latched paging byte.

Top module: `bank_pager_top`

## Requirements
- R1: After reset the paging byte is zero. The top window shows RAM page 0, the bottom window shows ROM page 0, `disp_page` is 5, and the register is unlocked.
- R2: A cycle with `io_wr` high loads `cpu_wdata` into the paging byte only when `cpu_addr[15]` = 0 and `cpu_addr[1]` = 0. All other address bits are ignored. An I/O write with either of those two bits at 1 leaves the mapping unchanged.
- R3: Addresses 0x4000–0x7FFF map to RAM page 5, and addresses 0x8000–0xBFFF map to RAM page 2, whatever the paging byte holds. For these, `map_rom` = 0.
- R4: Addresses 0xC000–0xFFFF map to the RAM page given by paging byte bits [2:0], with `map_rom` = 0.
- R5: Addresses 0x0000–0x3FFF give `map_rom` = 1, and `map_page` = {2'b00, paging byte bit 4}.
- R6: `disp_page` is 5 when paging byte bit 3 is 0, and 7 when it is 1.
- R7: Once paging byte bit 5 has been loaded as 1, every later I/O write is ignored until reset.
- R8: `ram_we` is 1 exactly when `mem_req` and `mem_wr` are both 1 and the address is not in the ROM window. A write into the ROM window gives `ram_we` = 0.
- R9: `contended` is 1 exactly when `mem_req` is 1 and the access resolves to RAM page 1, 3, 5 or 7. ROM accesses are never contended.
- R10: `map_offset` equals `cpu_addr[13:0]`. A paging value loaded by an I/O write in one cycle governs the mapping from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data (paging byte on I/O writes) |
| io_wr | input | 1 | I/O write cycle strobe, one clock per write |
| mem_req | input | 1 | Memory access in progress |
| mem_wr | input | 1 | Memory access is a write |
| map_rom | output | 1 | Address resolves to ROM |
| map_page | output | 3 | Physical page number (ROM page in bit 0) |
| map_offset | output | 14 | Offset within the 16 KB page |
| ram_we | output | 1 | Write enable to RAM |
| contended | output | 1 | Access lands in a contended RAM page |
| disp_page | output | 3 | RAM page read by the display side |

## Verification
The assertions assume that `io_wr` and `mem_req` are never high in the same cycle, because a processor cycle is either an I/O cycle or a memory cycle. They also assume that reset is held for at least two clocks, so the stability checks on `disp_page` compare against a value taken during reset. The stimulus drives a single cycle type per clock and otherwise stays idle. It first exercises the port decode with both excluded address lines set. It then runs random paging values with the lock bit masked off, so the lock is only set at the end of the run, where it is tested directly. A final reset shows the lock clearing.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int PAGE_W   = 3;
  localparam int NUM_PAGE = 1 << PAGE_W;
  localparam int WIN_W    = 2;
  localparam int NUM_WIN  = 1 << WIN_W;

  // fixed page per window slot {w3,w2,w1,w0}; only middle windows use it
  localparam logic [NUM_WIN*PAGE_W-1:0] FIXED_MAP = {3'd0, 3'd2, 3'd5, 3'd0};
  // odd pages are contended
  localparam logic [NUM_PAGE-1:0] CONT_MASK = 8'hAA;

  localparam logic [PAGE_W-1:0] DISP_NORM = 3'd5;
  localparam logic [PAGE_W-1:0] DISP_ALT  = 3'd7;

  typedef struct packed {
    logic              lock;
    logic              rom_sel;
    logic              disp_alt;
    logic [PAGE_W-1:0] top_page;
  } page_cfg_t;
endpackage

// File: rtl/bank_port_decode.sv
module bank_port_decode
  import bank_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TOP_LSB  = 0,
  parameter int DISP_BIT = 3,
  parameter int ROM_BIT  = 4,
  parameter int LOCK_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_hi,
  input  logic              sel_lo,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] wdata,
  output page_cfg_t         cfg
);
  logic      hit;
  page_cfg_t cfg_d;

  assign hit = io_wr & ~sel_hi & ~sel_lo & ~cfg.lock;

  always_comb begin
    cfg_d          = cfg;
    if (hit) begin
      cfg_d.top_page = wdata[TOP_LSB +: PAGE_W];
      cfg_d.disp_alt = wdata[DISP_BIT];
      cfg_d.rom_sel  = wdata[ROM_BIT];
      cfg_d.lock     = wdata[LOCK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_d;
  end

  logic unused_data;
  assign unused_data = ^{wdata[DATA_W-1:LOCK_BIT+1]};
endmodule

// File: rtl/bank_addr_map.sv
module bank_addr_map
  import bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int OFFS_W = ADDR_W - WIN_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_req,
  input  logic              mem_wr,
  input  logic              rom_sel,
  input  logic [PAGE_W-1:0] top_page,
  output logic              is_rom,
  output logic [PAGE_W-1:0] page,
  output logic [OFFS_W-1:0] offset,
  output logic              we,
  output logic              slow
);
  logic [PAGE_W-1:0] win_page [NUM_WIN];
  logic              win_rom  [NUM_WIN];
  logic [WIN_W-1:0]  win;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    if (w == 0) begin : g_rom
      assign win_page[w] = {{(PAGE_W-1){1'b0}}, rom_sel};
      assign win_rom[w]  = 1'b1;
    end else if (w == NUM_WIN-1) begin : g_sw
      assign win_page[w] = top_page;
      assign win_rom[w]  = 1'b0;
    end else begin : g_fix
      assign win_page[w] = FIXED_MAP[w*PAGE_W +: PAGE_W];
      assign win_rom[w]  = 1'b0;
    end
  end

  assign win    = addr[ADDR_W-1 -: WIN_W];
  assign page   = win_page[win];
  assign is_rom = win_rom[win];
  assign offset = addr[OFFS_W-1:0];
  assign we     = mem_req & mem_wr & ~is_rom;
  assign slow   = mem_req & ~is_rom & CONT_MASK[page];
endmodule

// File: rtl/bank_pager_top.sv
module bank_pager_top
  import bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int OFFS_W = ADDR_W - WIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              io_wr,
  input  logic              mem_req,
  input  logic              mem_wr,
  output logic              map_rom,
  output logic [PAGE_W-1:0] map_page,
  output logic [OFFS_W-1:0] map_offset,
  output logic              ram_we,
  output logic              contended,
  output logic [PAGE_W-1:0] disp_page
);
  page_cfg_t cfg_q;

  bank_port_decode #(.DATA_W(DATA_W)) i_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_hi (cpu_addr[ADDR_W-1]),
    .sel_lo (cpu_addr[1]),
    .io_wr  (io_wr),
    .wdata  (cpu_wdata),
    .cfg    (cfg_q)
  );

  bank_addr_map #(.ADDR_W(ADDR_W)) i_map (
    .addr     (cpu_addr),
    .mem_req  (mem_req),
    .mem_wr   (mem_wr),
    .rom_sel  (cfg_q.rom_sel),
    .top_page (cfg_q.top_page),
    .is_rom   (map_rom),
    .page     (map_page),
    .offset   (map_offset),
    .we       (ram_we),
    .slow     (contended)
  );

  assign disp_page = cfg_q.disp_alt ? DISP_ALT : DISP_NORM;
endmodule

// File: rtl/bank_pager_chk.sv
module bank_pager_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        io_wr,
  input logic        mem_req,
  input logic        mem_wr,
  input logic        map_rom,
  input logic [2:0]  map_page,
  input logic [13:0] map_offset,
  input logic        ram_we,
  input logic        contended,
  input logic [2:0]  disp_page,
  input logic        cfg_lock
);
  p_port_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (cpu_addr[15] || cpu_addr[1])) |=> $stable(disp_page));

  p_win1_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01) |-> (!map_rom && map_page == 3'd5));

  p_win2_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b10) |-> (!map_rom && map_page == 3'd2));

  p_disp_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_page == 3'd5 || disp_page == 3'd7));

  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> (cfg_lock && $stable(disp_page)));

  p_rom_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_wr && cpu_addr[15:14] == 2'b00) |-> !ram_we);

  p_win1_slow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && cpu_addr[15:14] == 2'b01) |-> contended);

  p_rom_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    map_rom |-> !contended);

  p_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (map_offset == cpu_addr[13:0]));
endmodule

bind bank_pager_top bank_pager_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_addr   (cpu_addr),
  .io_wr      (io_wr),
  .mem_req    (mem_req),
  .mem_wr     (mem_wr),
  .map_rom    (map_rom),
  .map_page   (map_page),
  .map_offset (map_offset),
  .ram_we     (ram_we),
  .contended  (contended),
  .disp_page  (disp_page),
  .cfg_lock   (cfg_q.lock)
);

// File: tb/test_bank_pager_top.sv
module test_bank_pager_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        io_wr = 1'b0, mem_req = 1'b0, mem_wr = 1'b0;
  logic        map_rom, ram_we, contended;
  logic [2:0]  map_page, disp_page;
  logic [13:0] map_offset;

  int checks = 0, errors = 0;
  logic [5:0] m_byte;
  bit done = 0;

  always #2 clk = ~clk;

  bank_pager_top i_bank_pager_top (.*);

  // reference model of the paging byte
  always @(posedge clk) begin
    if (!rst_n) m_byte <= '0;
    else if (io_wr && !cpu_addr[15] && !cpu_addr[1] && !m_byte[5])
      m_byte <= cpu_wdata[5:0];
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (cpu_addr[15:14])
        2'b00: begin check("R5 rom", map_rom, 1); check("R5 page", map_page, m_byte[4]); end
        2'b01: begin check("R3 rom", map_rom, 0); check("R3 page", map_page, 5); end
        2'b10: begin check("R3 rom", map_rom, 0); check("R3 page", map_page, 2); end
        default: begin check("R4 rom", map_rom, 0); check("R4 page", map_page, m_byte[2:0]); end
      endcase
      check("R6 disp", disp_page, m_byte[3] ? 7 : 5);
      check("R8 we", ram_we, int'(mem_req && mem_wr && cpu_addr[15:14] != 2'b00));
      if (mem_req) begin
        check("R10 offset", map_offset, cpu_addr[13:0]);
        if (cpu_addr[15:14] == 2'b00) check("R9 rom", contended, 0);
        else check("R9 slow", contended, int'(map_page[0]));
      end else check("R9 idle", contended, 0);
    end
  end

  task automatic idle();
    @(posedge clk); #1;
    io_wr = 0; mem_req = 0; mem_wr = 0;
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(posedge clk); #1;
    cpu_addr = a; cpu_wdata = d; io_wr = 1; mem_req = 0; mem_wr = 0;
    idle();
  endtask

  task automatic access(logic [15:0] a, logic wr);
    @(posedge clk); #1;
    cpu_addr = a; mem_req = 1; mem_wr = wr; io_wr = 0;
    @(negedge clk); #0.5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cpu_addr = 16'hC000;
    @(negedge clk);
    check("R1 top page", map_page, 0);
    check("R1 disp", disp_page, 5);
    rst_n = 1;
    access(16'h0000, 0);
    check("R1 rom page", map_page, 0);
    check("R1 rom flag", map_rom, 1);

    io_write(16'h7FFD, 8'h03);
    access(16'hC123, 0);
    check("R4 top after write", map_page, 3);
    check("R9 page3 slow", contended, 1);
    io_write(16'hFFFD, 8'h06);
    access(16'hC000, 0);
    check("R2 A15 set ignored", map_page, 3);
    io_write(16'h7FFF, 8'h0E);
    access(16'hC000, 0);
    check("R2 A1 set ignored", map_page, 3);
    check("R2 disp unchanged", disp_page, 5);
    io_write(16'h0000, 8'h1C);
    access(16'hC000, 0);
    check("R2 other bits ignored", map_page, 4);
    check("R9 page4 fast", contended, 0);
    check("R6 alt display", disp_page, 7);
    access(16'h2ABC, 1);
    check("R5 rom page1", map_page, 1);
    check("R8 rom write blocked", ram_we, 0);
    check("R10 offset", map_offset, 14'h2ABC);
    access(16'hC010, 1);
    check("R8 ram write", ram_we, 1);
    access(16'h4000, 0);
    check("R3 win1", map_page, 5);
    check("R9 page5 slow", contended, 1);

    for (int i = 0; i < 3000; i++) begin
      int kind = $urandom_range(0, 3);
      if (kind == 0) io_write(16'($urandom) & 16'h7FFD | (16'($urandom_range(0,1)) << 1),
                              8'($urandom) & 8'hDF);
      else if (kind == 3) idle();
      else access(16'($urandom), 1'($urandom));
    end

    io_write(16'h3FF1, 8'h27);
    access(16'hFFFF, 0);
    check("R7 lock write taken", map_page, 7);
    io_write(16'h7FFD, 8'h08);
    access(16'hC000, 0);
    check("R7 locked page", map_page, 7);
    check("R7 locked disp", disp_page, 5);
    access(16'h0000, 0);
    check("R7 locked rom", map_page, 0);
    idle();

    @(posedge clk); #1; rst_n = 0;
    repeat (2) @(posedge clk);
    #1; rst_n = 1;
    io_write(16'h7FFD, 8'h01);
    access(16'hC000, 0);
    check("R1 unlocked after reset", map_page, 1);
    idle();
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule